// File: doc/BRIEF.md
# Two-Level Address Translation Walker

The walker turns a 32-bit virtual address into a physical address by fetching two table words from memory. The top twelve address bits select one of 4096 four-byte directory words. The directory starts at the address on the table base input. A valid directory word names a second-level table of 256 four-byte page words, and the middle eight address bits select one of them. A valid page word supplies the page frame and a 4-bit permission index. The low twelve bits of the virtual address pass through unchanged as the offset within the page.

One translation runs at a time. A client raises a request with a virtual address and the walker accepts it while its grant is high. The walker then issues single-word reads on a pulse/response memory port and finishes with a one-cycle done pulse. At that pulse the result outputs hold either the translation or a fault status naming the level whose word was invalid. Each level also keeps the last virtual address that faulted at that level. A directory fault ends the walk without a second read.

Top module: `pt_walker`

## Requirements
- R1: After reset, gnt_o is 1; done_o, mem_req_o, paddr_o, perm_o, status_o, l1_fault_va_o and l2_fault_va_o are all 0.
- R2: A request is accepted on a clock edge where req_i and gnt_o are both 1. gnt_o stays 0 from that edge until the edge that raises done_o. A req_i raised while gnt_o is 0 starts no walk.
- R3: In the cycle after acceptance, mem_req_o is 1 for exactly one cycle, and mem_addr_o equals tbase_i + 4 × vaddr[31:20].
- R4: A directory word is valid only when its bits 1:0 equal 01. When it is valid, a second one-cycle mem_req_o follows in the cycle after the response, with mem_addr_o = {word[31:10], 10'b0} + 4 × vaddr[19:12].
- R5: A page word is valid when its bit 1 is 1. When it is valid, the done pulse carries paddr_o = {word[31:12], vaddr[11:0]}, perm_o = word[7:4] and status_o = 0.
- R6: An invalid directory word ends the walk with done_o in the cycle after the response. status_o then has only bit 16 set, paddr_o and perm_o are 0, no second read is issued, and l1_fault_va_o takes the faulting virtual address.
- R7: An invalid page word ends the walk with status_o having only bit 17 set and paddr_o and perm_o at 0. l2_fault_va_o takes the faulting virtual address.
- R8: mem_rvalid_i is taken only in the two states that wait for a response. A response pulse while idle or in a read-issue cycle has no effect on the walk or its result.
- R9: done_o lasts exactly one cycle. paddr_o, perm_o and status_o hold their values until the next done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tbase_i | input | 32 | Physical address of the directory |
| req_i | input | 1 | Translation request |
| vaddr_i | input | 32 | Virtual address to translate |
| gnt_o | output | 1 | Walker idle, request is accepted |
| mem_req_o | output | 1 | One-cycle word read pulse |
| mem_addr_o | output | 32 | Word read address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| done_o | output | 1 | Walk finished, one cycle |
| paddr_o | output | 32 | Translated physical address |
| perm_o | output | 4 | Permission index from the page word |
| status_o | output | 18 | Fault status: bit 16 directory, bit 17 page |
| l1_fault_va_o | output | 32 | Last address with a directory fault |
| l2_fault_va_o | output | 32 | Last address with a page fault |

## Verification
A state register stuck in or skipping a waiting state shows up at the ports within one or two cycles. The cause is a missing or extra mem_req_o pulse, or a done_o that never comes. Address arithmetic errors appear on mem_addr_o in the issue cycle, before any data returns. A wrong validity decode appears at the done pulse as a fault flag where a translation was due, or the reverse. A response taken outside a waiting state corrupts that walk's result, which is checked at the very next done pulse.

// File: rtl/pt_walker.sv
module pt_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] tbase_i,
  input  logic        req_i,
  input  logic [31:0] vaddr_i,
  output logic        gnt_o,
  output logic        mem_req_o,
  output logic [31:0] mem_addr_o,
  input  logic        mem_rvalid_i,
  input  logic [31:0] mem_rdata_i,
  output logic        done_o,
  output logic [31:0] paddr_o,
  output logic [3:0]  perm_o,
  output logic [17:0] status_o,
  output logic [31:0] l1_fault_va_o,
  output logic [31:0] l2_fault_va_o
);

  localparam int OFF_W  = 12;
  localparam int PIX_W  = 8;
  localparam int DIX_W  = 32 - OFF_W - PIX_W;
  localparam int PT_LSB = 10;
  localparam int FLT_L1 = 16;
  localparam int FLT_L2 = 17;

  typedef enum logic [2:0] {S_IDLE, S_DREQ, S_DWAIT, S_PREQ, S_PWAIT} st_t;

  st_t         st;
  logic [31:0] va_q, addr_q, pa_q, l1_q, l2_q;
  logic [3:0]  perm_q;
  logic [17:0] stat_q;
  logic        done_q;

  logic take, d_rsp, p_rsp, d_ok, p_ok;
  logic [31:0] dir_addr, pg_addr;

  assign gnt_o    = (st == S_IDLE);
  assign take     = req_i && gnt_o;
  assign d_rsp    = (st == S_DWAIT) && mem_rvalid_i;
  assign p_rsp    = (st == S_PWAIT) && mem_rvalid_i;
  assign d_ok     = (mem_rdata_i[1:0] == 2'b01);
  assign p_ok     = mem_rdata_i[1];
  assign dir_addr = tbase_i + {{(30-DIX_W){1'b0}}, vaddr_i[31 -: DIX_W], 2'b00};
  assign pg_addr  = {mem_rdata_i[31:PT_LSB], {PT_LSB{1'b0}}}
                  + {{(30-PIX_W){1'b0}}, va_q[OFF_W +: PIX_W], 2'b00};

  assign mem_req_o     = (st == S_DREQ) || (st == S_PREQ);
  assign mem_addr_o    = addr_q;
  assign done_o        = done_q;
  assign paddr_o       = pa_q;
  assign perm_o        = perm_q;
  assign status_o      = stat_q;
  assign l1_fault_va_o = l1_q;
  assign l2_fault_va_o = l2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      va_q   <= '0;
      addr_q <= '0;
      pa_q   <= '0;
      perm_q <= '0;
      stat_q <= '0;
      l1_q   <= '0;
      l2_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (take) begin
          va_q   <= vaddr_i;
          addr_q <= dir_addr;
          st     <= S_DREQ;
        end
        S_DREQ: st <= S_DWAIT;
        S_DWAIT: if (d_rsp) begin
          if (d_ok) begin
            addr_q <= pg_addr;
            st     <= S_PREQ;
          end else begin
            pa_q           <= '0;
            perm_q         <= '0;
            stat_q         <= '0;
            stat_q[FLT_L1] <= 1'b1;
            l1_q           <= va_q;
            done_q         <= 1'b1;
            st             <= S_IDLE;
          end
        end
        S_PREQ: st <= S_PWAIT;
        S_PWAIT: if (p_rsp) begin
          stat_q <= '0;
          done_q <= 1'b1;
          st     <= S_IDLE;
          if (p_ok) begin
            pa_q   <= {mem_rdata_i[31:OFF_W], va_q[OFF_W-1:0]};
            perm_q <= mem_rdata_i[7:4];
          end else begin
            pa_q           <= '0;
            perm_q         <= '0;
            stat_q[FLT_L2] <= 1'b1;
            l2_q           <= va_q;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r2_busy_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> !gnt_o);

  a_r3_dir_issue: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && gnt_o) |=> (mem_req_o && mem_addr_o ==
      $past(tbase_i) + {18'b0, $past(vaddr_i[31:20]), 2'b00}));

  a_r3_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |=> !mem_req_o);

  a_r6_fault_clears_result: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && status_o != 18'd0) |-> (paddr_o == 32'd0 && perm_o == 4'd0));

  a_r6_single_flag: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !(status_o[FLT_L1] && status_o[FLT_L2]));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && $stable(paddr_o) && $stable(status_o)));

endmodule

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] tbase_i = 32'h4000_0000;
  logic        req_i = 1'b0;
  logic [31:0] vaddr_i = '0;
  logic        gnt_o, mem_req_o, mem_rvalid_i = 1'b0, done_o;
  logic [31:0] mem_addr_o, mem_rdata_i = '0, paddr_o, l1_fault_va_o, l2_fault_va_o;
  logic [3:0]  perm_o;
  logic [17:0] status_o;

  int checks = 0;
  int errors = 0;
  int nreq = 0;

  always #4 clk = ~clk;

  pt_walker u_pt_walker (
    .clk(clk), .rst_n(rst_n), .tbase_i(tbase_i), .req_i(req_i), .vaddr_i(vaddr_i),
    .gnt_o(gnt_o), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i), .done_o(done_o),
    .paddr_o(paddr_o), .perm_o(perm_o), .status_o(status_o),
    .l1_fault_va_o(l1_fault_va_o), .l2_fault_va_o(l2_fault_va_o));

  always @(posedge clk) if (rst_n && mem_req_o) nreq <= nreq + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // va, directory word, page word, expected fault (0 none, 1 dir, 2 page)
  localparam logic [97:0] VEC [6] = '{
    {32'h0030_5ABC, 32'h8000_0401, 32'h1234_5032, 2'd0},
    {32'hFFFF_FFFF, 32'hFFFF_FC01, 32'hFFFF_F0F2, 2'd0},
    {32'h0000_0000, 32'h0000_0C03, 32'h0000_0000, 2'd1},
    {32'h1230_0000, 32'h0000_0402, 32'h0000_0000, 2'd1},
    {32'h0A0B_C123, 32'h4000_0001, 32'h5555_50F0, 2'd2},
    {32'h7FF0_1FFF, 32'h0001_0001, 32'hABCD_E0A2, 2'd0}
  };

  task automatic walk(input logic [31:0] va, input logic [31:0] dte, input logic [31:0] pte,
                      input logic [1:0] fexp, input int lat, input bit stray);
    int n0;
    logic [31:0] pta;
    n0 = nreq;
    @(negedge clk);
    req_i = 1'b1; vaddr_i = va;
    @(negedge clk);
    req_i = 1'b0;
    chk("R3 dir req", {31'd0, mem_req_o}, 32'd1);
    chk("R3 dir addr", mem_addr_o, tbase_i + {18'd0, va[31:20], 2'b00});
    if (stray) begin mem_rvalid_i = 1'b1; mem_rdata_i = 32'h0; end
    @(negedge clk);
    mem_rvalid_i = 1'b0;
    if (stray) begin
      chk("R8 stray ignored, still busy", {31'd0, done_o}, 32'd0);
      req_i = 1'b1; vaddr_i = ~va;
      chk("R2 no grant while busy", {31'd0, gnt_o}, 32'd0);
    end
    repeat (lat) @(negedge clk);
    req_i = 1'b0;
    mem_rvalid_i = 1'b1; mem_rdata_i = dte;
    @(negedge clk);
    mem_rvalid_i = 1'b0;
    if (fexp == 2'd1) begin
      chk("R6 done", {31'd0, done_o}, 32'd1);
      chk("R6 status", {14'd0, status_o}, 32'h0001_0000);
      chk("R6 paddr", paddr_o, 32'd0);
      chk("R6 perm", {28'd0, perm_o}, 32'd0);
      chk("R6 l1 va", l1_fault_va_o, va);
      chk("R6 no second read", {31'd0, mem_req_o}, 32'd0);
    end else begin
      pta = {dte[31:10], 10'd0};
      chk("R4 page req", {31'd0, mem_req_o}, 32'd1);
      chk("R4 page addr", mem_addr_o, pta + {22'd0, va[19:12], 2'b00});
      if (stray) begin mem_rvalid_i = 1'b1; mem_rdata_i = 32'h0; end
      @(negedge clk);
      mem_rvalid_i = 1'b0;
      repeat (lat) @(negedge clk);
      mem_rvalid_i = 1'b1; mem_rdata_i = pte;
      @(negedge clk);
      mem_rvalid_i = 1'b0;
      chk("R5 done", {31'd0, done_o}, 32'd1);
      if (fexp == 2'd2) begin
        chk("R7 status", {14'd0, status_o}, 32'h0002_0000);
        chk("R7 paddr", paddr_o, 32'd0);
        chk("R7 l2 va", l2_fault_va_o, va);
      end else begin
        chk("R5 status", {14'd0, status_o}, 32'd0);
        chk("R5 paddr", paddr_o, {pte[31:12], va[11:0]});
        chk("R5 perm", {28'd0, perm_o}, {28'd0, pte[7:4]});
      end
    end
    chk("R2 grant back", {31'd0, gnt_o}, 32'd1);
    @(negedge clk);
    chk("R9 done one cycle", {31'd0, done_o}, 32'd0);
    chk("R9 status held", {14'd0, status_o}, (fexp == 2'd1) ? 32'h0001_0000 :
                                            (fexp == 2'd2) ? 32'h0002_0000 : 32'd0);
    chk("R2 read count", nreq - n0, (fexp == 2'd1) ? 32'd1 : 32'd2);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1;
    chk("R1 grant", {31'd0, gnt_o}, 32'd1);
    chk("R1 done", {31'd0, done_o}, 32'd0);
    chk("R1 mem_req", {31'd0, mem_req_o}, 32'd0);
    chk("R1 paddr", paddr_o, 32'd0);
    chk("R1 status", {14'd0, status_o}, 32'd0);
    chk("R1 fault va", l1_fault_va_o | l2_fault_va_o, 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 6; i++)
      walk(VEC[i][97:66], VEC[i][65:34], VEC[i][33:2], VEC[i][1:0], i % 3, 1'b0);

    // R8: response pulses while idle
    mem_rvalid_i = 1'b1; mem_rdata_i = 32'h0;
    repeat (2) @(negedge clk);
    mem_rvalid_i = 1'b0;
    chk("R8 idle response no done", {31'd0, done_o}, 32'd0);
    chk("R8 idle response no read", {31'd0, mem_req_o}, 32'd0);

    // R8 and R2: stray pulses in issue cycles, request held while busy
    walk(32'h0030_5ABC, 32'h8000_0401, 32'h1234_5032, 2'd0, 2, 1'b1);
    tbase_i = 32'h0010_0000;
    walk(32'h0110_0000, 32'h0000_0003, 32'h0, 2'd1, 1, 1'b1);
    chk("R7 l2 va kept after dir fault", l2_fault_va_o, 32'h0A0B_C123);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule